// File: doc/BRIEF.md
# Fixed-Point Arithmetic Exception Unit

This unit executes one signed 32-bit fixed-point operation per clock and classifies its arithmetic exceptions in the same step. It supports add, subtract, arithmetic left shift, complement (sign control) and signed divide. It also converts an 8-byte packed-decimal operand to binary. The result, the destination write strobe, the condition code, the interrupt request with its cause and a sticky interrupt flag are all registered. They appear one clock after the operation is presented.

The exceptions fall into two classes. Overflow is a completing exception: the truncated result is still written and the condition code becomes 3, and the interrupt is raised only when the program mask bit allows it. Divide errors and data errors suppress the operation: nothing is written and the condition code keeps its value.

Top module: `fxp_exc_unit`

## Requirements
- R1: Opcodes are 0 add, 1 subtract, 2 shift left, 3 complement, 4 divide, 5 decimal convert. Add and subtract write the 32-bit two's-complement result with `wr_en` high. Without overflow, `cc` is 0 for a zero result, 1 for a negative result and 2 for a positive result.
- R2: When add, subtract, shift or complement overflows, the result truncated to 32 bits is still written (`wr_en` high) and `cc` becomes 3.
- R3: An overflow raises `irq` with `irq_cause` 0 only when `pmask` is 1. When `pmask` is 0 there is no interrupt and `ifr_flag` is not set.
- R4: Complementing 0x80000000 overflows. A left shift by `op_b[4:0]` overflows when any bit shifted through the sign position differs from the original sign. Otherwise the shift result is the operand shifted left with zeros filled in.
- R5: Divide writes the signed quotient of `op_a / op_b`, truncated toward zero, and leaves `cc` unchanged.
- R6: A divisor of zero, or a quotient that does not fit (0x80000000 / -1), raises a divide error (`irq_cause` 1). In that case `wr_en` stays low, `result` and `cc` are unchanged, and this happens regardless of `pmask`.
- R7: Decimal convert reads 15 digits from `dec_in[63:4]`, most significant digit first, and a sign nibble from `dec_in[3:0]`. Sign codes 0xA, 0xC, 0xE and 0xF mean plus; 0xB and 0xD mean minus. The binary value is written and `cc` is unchanged.
- R8: A digit nibble above 9, or a sign nibble of 0 to 9, raises a data error (`irq_cause` 2) with no write and no change to `cc`. A data error takes priority over a range error.
- R9: A conversion whose magnitude exceeds 2^31-1 (plus) or 2^31 (minus) raises a divide error (`irq_cause` 1) with no write.
- R10: Any raised interrupt sets `ifr_flag`, which stays set until `flag_clr` is high in a cycle with no new interrupt. A new interrupt and `flag_clr` in the same cycle leave the flag set.
- R11: Synchronous reset clears `result`, `wr_en`, `cc`, `irq`, `irq_cause` and `ifr_flag` to 0.
- R12: With `op_valid` low, or with opcode 6 or 7, no write and no interrupt occur, and `result` and `cc` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation select |
| op_a | input | 32 | First operand / dividend / shifted value |
| op_b | input | 32 | Second operand / divisor / shift count in bits 4:0 |
| dec_in | input | 64 | Packed-decimal operand for conversion |
| pmask | input | 1 | Program mask bit enabling the overflow interrupt |
| flag_clr | input | 1 | Clears the interrupt flag |
| result | output | 32 | Last written result |
| wr_en | output | 1 | Destination write strobe |
| cc | output | 2 | Condition code |
| irq | output | 1 | Interrupt request pulse |
| irq_cause | output | 2 | 0 overflow, 1 divide error, 2 data error |
| ifr_flag | output | 1 | Sticky interrupt flag |

## Verification
Clearing the interrupt flag and raising a new interrupt can fall in the same cycle. The bench provokes this by asserting `flag_clr` together with a divide by zero, then checks one clock later that `irq` is high and that `ifr_flag` is still set. A second, separate case asserts `flag_clr` with no interrupt to show that clearing works on its own. Masked overflow is also checked to complete its write while leaving the flag cleared.

// File: rtl/fxp_pkg.sv
package fxp_pkg;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_SHL = 3'd2;
  localparam logic [2:0] OP_NEG = 3'd3;
  localparam logic [2:0] OP_DIV = 3'd4;
  localparam logic [2:0] OP_CVB = 3'd5;

  localparam logic [1:0] CAUSE_OVF  = 2'd0;
  localparam logic [1:0] CAUSE_DIV  = 2'd1;
  localparam logic [1:0] CAUSE_DATA = 2'd2;

  localparam logic [1:0] CC_ZERO = 2'd0;
  localparam logic [1:0] CC_NEG  = 2'd1;
  localparam logic [1:0] CC_POS  = 2'd2;
  localparam logic [1:0] CC_OVF  = 2'd3;
endpackage

// File: rtl/fxp_alu.sv
module fxp_alu #(
  parameter int W = 32
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         ovf
);
  import fxp_pkg::*;
  localparam int SHW = $clog2(W);

  logic [W-1:0]   sum, dif;
  logic [2*W-1:0] ext;

  assign sum = a + b;
  assign dif = a - b;
  assign ext = {{W{a[W-1]}}, a} << b[SHW-1:0];

  always_comb begin
    res = '0;
    ovf = 1'b0;
    unique case (op)
      OP_ADD: begin
        res = sum;
        ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
      end
      OP_SUB: begin
        res = dif;
        ovf = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
      end
      OP_SHL: begin
        res = ext[W-1:0];
        ovf = !((&ext[2*W-1:W-1]) || (~|ext[2*W-1:W-1]));
      end
      OP_NEG: begin
        res = -a;
        ovf = (a == {1'b1, {(W-1){1'b0}}});
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fxp_div.sv
module fxp_div #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] q,
  output logic         err
);
  localparam logic [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] dsr;

  assign err = (b == '0) || ((a == MIN_VAL) && (b == '1));
  assign dsr = err ? {{(W-1){1'b0}}, 1'b1} : b;
  assign q   = $signed(a) / $signed(dsr);
endmodule

// File: rtl/fxp_cvb.sv
module fxp_cvb #(
  parameter int W      = 32,
  parameter int DIGITS = 15
) (
  input  logic [4*DIGITS+3:0] dec,
  output logic [W-1:0]        val,
  output logic                data_err,
  output logic                range_err
);
  localparam int ACCW = 4*DIGITS + 4;
  localparam logic [ACCW-1:0] POS_LIM = (ACCW'(1) << (W-1)) - ACCW'(1);
  localparam logic [ACCW-1:0] NEG_LIM = ACCW'(1) << (W-1);

  logic [DIGITS-1:0] bad_dig;
  logic [3:0]        sgn;
  logic              sgn_plus, sgn_minus;
  logic [ACCW-1:0]   mag;

  genvar gi;
  generate
    for (gi = 0; gi < DIGITS; gi++) begin : g_dig
      assign bad_dig[gi] = dec[4*gi+7 -: 4] > 4'd9;
    end
  endgenerate

  assign sgn       = dec[3:0];
  assign sgn_plus  = (sgn == 4'hA) || (sgn == 4'hC) || (sgn == 4'hE) || (sgn == 4'hF);
  assign sgn_minus = (sgn == 4'hB) || (sgn == 4'hD);

  always_comb begin
    mag = '0;
    for (int i = DIGITS-1; i >= 0; i--) begin
      mag = (mag << 3) + (mag << 1) + {{(ACCW-4){1'b0}}, dec[4*i+7 -: 4]};
    end
  end

  assign data_err  = (|bad_dig) || !(sgn_plus || sgn_minus);
  assign range_err = sgn_minus ? (mag > NEG_LIM) : (mag > POS_LIM);
  assign val       = sgn_minus ? -mag[W-1:0] : mag[W-1:0];
endmodule

// File: rtl/fxp_exc_unit.sv
module fxp_exc_unit #(
  parameter int W      = 32,
  parameter int DIGITS = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic [2:0]          op_code,
  input  logic [W-1:0]        op_a,
  input  logic [W-1:0]        op_b,
  input  logic [4*DIGITS+3:0] dec_in,
  input  logic                pmask,
  input  logic                flag_clr,
  output logic [W-1:0]        result,
  output logic                wr_en,
  output logic [1:0]          cc,
  output logic                irq,
  output logic [1:0]          irq_cause,
  output logic                ifr_flag
);
  import fxp_pkg::*;

  logic [W-1:0] alu_res, div_q, cvb_val;
  logic         alu_ovf, div_err, cvb_data_err, cvb_range_err;

  fxp_alu #(.W(W)) u_alu (
    .op(op_code), .a(op_a), .b(op_b), .res(alu_res), .ovf(alu_ovf)
  );

  fxp_div #(.W(W)) u_div (
    .a(op_a), .b(op_b), .q(div_q), .err(div_err)
  );

  fxp_cvb #(.W(W), .DIGITS(DIGITS)) u_cvb (
    .dec(dec_in), .val(cvb_val), .data_err(cvb_data_err), .range_err(cvb_range_err)
  );

  logic [W-1:0] nxt_res;
  logic         nxt_wr, nxt_irq, nxt_cc_we;
  logic [1:0]   nxt_cause, nxt_cc;

  always_comb begin
    nxt_res   = alu_res;
    nxt_wr    = 1'b0;
    nxt_irq   = 1'b0;
    nxt_cause = CAUSE_OVF;
    nxt_cc_we = 1'b0;
    nxt_cc    = CC_ZERO;
    if (op_valid) begin
      unique case (op_code)
        OP_ADD, OP_SUB, OP_SHL, OP_NEG: begin
          nxt_wr    = 1'b1;
          nxt_cc_we = 1'b1;
          if (alu_ovf)                nxt_cc = CC_OVF;
          else if (alu_res == '0)     nxt_cc = CC_ZERO;
          else if (alu_res[W-1])      nxt_cc = CC_NEG;
          else                        nxt_cc = CC_POS;
          nxt_irq   = alu_ovf && pmask;
          nxt_cause = CAUSE_OVF;
        end
        OP_DIV: begin
          nxt_res   = div_q;
          nxt_wr    = !div_err;
          nxt_irq   = div_err;
          nxt_cause = CAUSE_DIV;
        end
        OP_CVB: begin
          nxt_res = cvb_val;
          if (cvb_data_err) begin
            nxt_irq   = 1'b1;
            nxt_cause = CAUSE_DATA;
          end else if (cvb_range_err) begin
            nxt_irq   = 1'b1;
            nxt_cause = CAUSE_DIV;
          end else begin
            nxt_wr = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      wr_en     <= 1'b0;
      cc        <= CC_ZERO;
      irq       <= 1'b0;
      irq_cause <= CAUSE_OVF;
      ifr_flag  <= 1'b0;
    end else begin
      wr_en     <= nxt_wr;
      irq       <= nxt_irq;
      irq_cause <= nxt_cause;
      if (nxt_wr)    result <= nxt_res;
      if (nxt_cc_we) cc     <= nxt_cc;
      if (nxt_irq)       ifr_flag <= 1'b1;
      else if (flag_clr) ifr_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/fxp_exc_chk.sv
module fxp_exc_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [2:0]   op_code,
  input logic [W-1:0] op_b,
  input logic         pmask,
  input logic         wr_en,
  input logic [1:0]   cc,
  input logic         irq,
  input logic [1:0]   irq_cause,
  input logic         ifr_flag
);
  import fxp_pkg::*;

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!wr_en && !irq && !ifr_flag && cc == CC_ZERO));

  a_r2_ovf_writes_cc3: assert property (@(posedge clk) disable iff (rst)
    (irq && irq_cause == CAUSE_OVF) |-> (wr_en && cc == CC_OVF));

  a_r3_ovf_needs_mask: assert property (@(posedge clk) disable iff (rst)
    (irq && irq_cause == CAUSE_OVF) |-> $past(pmask));

  a_r6_div_zero_suppress: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_DIV && op_b == '0) |=>
      (irq && irq_cause == CAUSE_DIV && !wr_en));

  a_r8_data_no_write: assert property (@(posedge clk) disable iff (rst)
    (irq && irq_cause == CAUSE_DATA) |-> !wr_en);

  a_r5_cc_kept: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_DIV || op_code == OP_CVB)) |=> $stable(cc));

  a_r10_flag_follows_irq: assert property (@(posedge clk) disable iff (rst)
    irq |-> ifr_flag);
endmodule

bind fxp_exc_unit fxp_exc_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_b(op_b),
  .pmask(pmask), .wr_en(wr_en), .cc(cc), .irq(irq), .irq_cause(irq_cause),
  .ifr_flag(ifr_flag)
);

// File: tb/fxp_exc_unit_tb.sv
module fxp_exc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [31:0] op_a, op_b;
  logic [63:0] dec_in;
  logic        pmask, flag_clr;
  logic [31:0] result;
  logic        wr_en, irq, ifr_flag;
  logic [1:0]  cc, irq_cause;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fxp_exc_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .dec_in(dec_in), .pmask(pmask), .flag_clr(flag_clr),
    .result(result), .wr_en(wr_en), .cc(cc), .irq(irq), .irq_cause(irq_cause),
    .ifr_flag(ifr_flag)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [63:0] dec;
    logic        pm;
    logic        ewr;
    logic [31:0] eres;
    logic        eirq;
    logic [1:0]  ecause;
    logic [1:0]  ecc;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'd5,         32'd7,         64'h0,                1'b1, 1'b1, 32'd12,        1'b0, 2'd0, 2'd2, 8'd1}, // R1
    '{3'd1, 32'd3,         32'd10,        64'h0,                1'b1, 1'b1, 32'hFFFFFFF9,  1'b0, 2'd0, 2'd1, 8'd1}, // R1
    '{3'd0, 32'h7FFFFFFF,  32'd1,         64'h0,                1'b1, 1'b1, 32'h80000000,  1'b1, 2'd0, 2'd3, 8'd2}, // R2
    '{3'd0, 32'h80000000,  32'h80000000,  64'h0,                1'b0, 1'b1, 32'h0,         1'b0, 2'd0, 2'd3, 8'd3}, // R3
    '{3'd1, 32'd0,         32'd0,         64'h0,                1'b1, 1'b1, 32'h0,         1'b0, 2'd0, 2'd0, 8'd1}, // R1
    '{3'd3, 32'h80000000,  32'd0,         64'h0,                1'b1, 1'b1, 32'h80000000,  1'b1, 2'd0, 2'd3, 8'd4}, // R4
    '{3'd3, 32'd5,         32'd0,         64'h0,                1'b1, 1'b1, 32'hFFFFFFFB,  1'b0, 2'd0, 2'd1, 8'd4}, // R4
    '{3'd2, 32'd1,         32'd4,         64'h0,                1'b1, 1'b1, 32'd16,        1'b0, 2'd0, 2'd2, 8'd4}, // R4
    '{3'd2, 32'h40000000,  32'd1,         64'h0,                1'b1, 1'b1, 32'h80000000,  1'b1, 2'd0, 2'd3, 8'd4}, // R4
    '{3'd2, 32'hFFFFFFFF,  32'd31,        64'h0,                1'b1, 1'b1, 32'h80000000,  1'b0, 2'd0, 2'd1, 8'd4}, // R4
    '{3'd4, 32'hFFFFFFF9,  32'd2,         64'h0,                1'b1, 1'b1, 32'hFFFFFFFD,  1'b0, 2'd0, 2'd1, 8'd5}, // R5
    '{3'd4, 32'd100,       32'd0,         64'h0,                1'b0, 1'b0, 32'hFFFFFFFD,  1'b1, 2'd1, 2'd1, 8'd6}, // R6
    '{3'd4, 32'h80000000,  32'hFFFFFFFF,  64'h0,                1'b1, 1'b0, 32'hFFFFFFFD,  1'b1, 2'd1, 2'd1, 8'd6}, // R6
    '{3'd5, 32'd0,         32'd0,         64'h000000000001234C, 1'b1, 1'b1, 32'd1234,      1'b0, 2'd0, 2'd1, 8'd7}, // R7
    '{3'd5, 32'd0,         32'd0,         64'h000000000000987D, 1'b1, 1'b1, 32'hFFFFFC25,  1'b0, 2'd0, 2'd1, 8'd7}, // R7
    '{3'd5, 32'd0,         32'd0,         64'h000002147483648C, 1'b1, 1'b0, 32'hFFFFFC25,  1'b1, 2'd1, 2'd1, 8'd9}, // R9
    '{3'd5, 32'd0,         32'd0,         64'h000002147483648D, 1'b1, 1'b1, 32'h80000000,  1'b0, 2'd0, 2'd1, 8'd9}, // R9
    '{3'd5, 32'd0,         32'd0,         64'h000000000000012A, 1'b1, 1'b1, 32'd12,        1'b0, 2'd0, 2'd1, 8'd7}, // R7
    '{3'd5, 32'd0,         32'd0,         64'h00000000000001AC, 1'b1, 1'b0, 32'd12,        1'b1, 2'd2, 2'd1, 8'd8}, // R8
    '{3'd5, 32'd0,         32'd0,         64'h0000000000000123, 1'b1, 1'b0, 32'd12,        1'b1, 2'd2, 2'd1, 8'd8}, // R8
    '{3'd5, 32'd0,         32'd0,         64'hA99999999999999C, 1'b1, 1'b0, 32'd12,        1'b1, 2'd2, 2'd1, 8'd8}, // R8
    '{3'd6, 32'd1,         32'd1,         64'h0,                1'b1, 1'b0, 32'd12,        1'b0, 2'd0, 2'd1, 8'd12},// R12
    '{3'd0, 32'd0,         32'd0,         64'h0,                1'b1, 1'b1, 32'd0,         1'b0, 2'd0, 2'd0, 8'd1}  // R1
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      finish_run();
    end
  end

  task automatic drive(input logic v, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [63:0] d, input logic pm,
                       input logic clr);
    op_valid = v; op_code = op; op_a = a; op_b = b; dec_in = d; pmask = pm; flag_clr = clr;
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, 3'd0, 32'd0, 32'd0, 64'd0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    // R11: reset state
    check(result == 32'd0 && wr_en == 1'b0, "R11 result/wr", {32'd0, result}, 64'd0);
    check(cc == 2'd0 && irq == 1'b0 && ifr_flag == 1'b0, "R11 cc/irq/flag",
          {59'd0, cc, irq, ifr_flag}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].dec, VECS[i].pm, 1'b0);
      @(negedge clk);
      check(wr_en == VECS[i].ewr, $sformatf("R%0d vec%0d wr_en", VECS[i].req, i),
            {63'd0, wr_en}, {63'd0, VECS[i].ewr});
      check(result == VECS[i].eres, $sformatf("R%0d vec%0d result", VECS[i].req, i),
            {32'd0, result}, {32'd0, VECS[i].eres});
      check(irq == VECS[i].eirq, $sformatf("R%0d vec%0d irq", VECS[i].req, i),
            {63'd0, irq}, {63'd0, VECS[i].eirq});
      if (VECS[i].eirq)
        check(irq_cause == VECS[i].ecause, $sformatf("R%0d vec%0d cause", VECS[i].req, i),
              {62'd0, irq_cause}, {62'd0, VECS[i].ecause});
      check(cc == VECS[i].ecc, $sformatf("R%0d vec%0d cc", VECS[i].req, i),
            {62'd0, cc}, {62'd0, VECS[i].ecc});
    end

    // R10: flag stuck after earlier interrupts
    check(ifr_flag == 1'b1, "R10 flag sticky", {63'd0, ifr_flag}, 64'd1);

    // R12: op_valid low with an add that would write
    drive(1'b0, 3'd0, 32'd9, 32'd9, 64'd0, 1'b1, 1'b0);
    @(negedge clk);
    check(!wr_en && !irq && result == 32'd0 && cc == 2'd0, "R12 idle no effect",
          {29'd0, wr_en, irq, cc, result}, 64'd0);
    check(ifr_flag == 1'b1, "R12 idle flag held", {63'd0, ifr_flag}, 64'd1);

    // R10: clear with no interrupt
    drive(1'b0, 3'd0, 32'd0, 32'd0, 64'd0, 1'b1, 1'b1);
    @(negedge clk);
    check(ifr_flag == 1'b0, "R10 flag cleared", {63'd0, ifr_flag}, 64'd0);

    // R3: masked overflow completes without interrupt or flag
    drive(1'b1, 3'd0, 32'h7FFFFFFF, 32'd1, 64'd0, 1'b0, 1'b0);
    @(negedge clk);
    check(wr_en && result == 32'h80000000 && cc == 2'd3, "R3 masked ovf writes",
          {result, 30'd0, cc}, {32'h80000000, 32'd3});
    check(!irq && !ifr_flag, "R3 masked ovf no irq/flag", {62'd0, irq, ifr_flag}, 64'd0);

    // R10: clear and new divide error in the same cycle -> set wins
    drive(1'b1, 3'd4, 32'd5, 32'd0, 64'd0, 1'b1, 1'b1);
    @(negedge clk);
    check(irq && irq_cause == 2'd1 && ifr_flag, "R10 set beats clear",
          {61'd0, irq, irq_cause, ifr_flag}, {61'd0, 1'b1, 2'd1, 1'b1});
    check(!wr_en && result == 32'h80000000, "R6 div by zero no write",
          {31'd0, wr_en, result}, {32'd0, 32'h80000000});

    drive(1'b0, 3'd0, 32'd0, 32'd0, 64'd0, 1'b0, 1'b0);
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule